// File: doc/BRIEF.md
# Exception Dispatch and State Save

This block sits beside a processor pipeline and records where and why control left normal flow. When a general exception is raised it stores the faulting program counter, the cause code and, for the address-carrying variant, the faulting virtual address. It sets the exception-mode flag and picks the user, kernel or double-exception vector. When a debug event is raised and the current interrupt level allows it, the block saves the program counter and the whole status word into the slots belonging to the debug level. It then raises the interrupt level to that level and picks the debug vector.

The chosen vector appears as a one-hot select together with a one-cycle taken pulse. These outputs are registered on the same clock edge that updates the saved registers. A simple write/read port with a register select gives software access to every saved register. Two parameters choose whether a dedicated double-exception PC register exists and which interrupt level debug events use.

Top module: `exc_dispatch`

## Requirements
- R1: After reset every readable register reads zero, and vec_taken, vec_sel and gen_dropped are zero.
- R2: A general raise while the exception-mode flag is clear stores fault_pc in EPC slot 1 (select 9). It selects the user vector (vec_sel bit 0) when the user-mode flag is set, and the kernel vector (vec_sel bit 1) when it is clear.
- R3: A general raise while the exception-mode flag is set selects the double vector (vec_sel bit 2). It stores fault_pc in the double PC register (select 3) when HAS_DEPC is 1, and in EPC slot 1 otherwise. With HAS_DEPC 0, select 3 reads zero.
- R4: Every taken general raise writes cause into the cause register (select 1) and sets the exception-mode flag. The user-mode flag keeps its value.
- R5: A taken general raise with with_vaddr high writes fault_vaddr into the address register (select 2). With with_vaddr low, that register keeps its value.
- R6: A taken debug raise writes dbg_cause into the debug cause register (select 4), fault_pc into EPC slot DEBUG_LEVEL (select 8+DEBUG_LEVEL) and the prior status word into EPS slot DEBUG_LEVEL (select 16+DEBUG_LEVEL). The status word is laid out as bits 3:0 interrupt level, bit 4 exception mode, bit 5 user mode, and it is read at select 0. The raise then sets the interrupt level to DEBUG_LEVEL and sets exception mode. It selects the debug vector (vec_sel bit 3).
- R7: A debug raise while the interrupt level is at or above DEBUG_LEVEL is ignored: no register changes and, alone, it produces no vec_taken.
- R8: When a general and a taken debug raise arrive together, the debug raise wins. gen_dropped pulses with vec_taken, and the cause register, the address register and EPC slot 1 are left unchanged.
- R9: vec_taken is a one-cycle pulse in the cycle after the raise edge, with exactly one vec_sel bit set. vec_sel is zero when vec_taken is low.
- R10: When sw_we is high, sw_wdata is written into the register at sw_sel. A raise in the same cycle takes precedence over the write. Selects that name no register (5 to 8, 16, 17, 24 and above) ignore writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_gen | input | 1 | General exception strobe |
| raise_dbg | input | 1 | Debug event strobe |
| with_vaddr | input | 1 | General raise also carries a faulting address |
| fault_pc | input | DATA_W | PC of the faulting instruction |
| cause | input | CAUSE_W | General exception cause code |
| fault_vaddr | input | DATA_W | Faulting virtual address |
| dbg_cause | input | CAUSE_W | Debug event cause code |
| sw_we | input | 1 | Software write enable |
| sw_sel | input | SEL_W | Software register select |
| sw_wdata | input | DATA_W | Software write data |
| sw_rdata | output | DATA_W | Software read data for sw_sel (combinational) |
| vec_sel | output | 4 | One-hot vector: user, kernel, double, debug (bits 0..3) |
| vec_taken | output | 1 | One-cycle pulse when a vector is taken |
| gen_dropped | output | 1 | General raise lost to a simultaneous debug raise |

## Verification
A wrong exception-mode or user-mode flag shows up in the cycle after the next raise as the wrong vec_sel bit, and as the PC landing in the wrong save register. A wrong interrupt level shows up as a debug event taken or refused against the gate. Because every register can be read back right after each raise, a misrouted save or a stray overwrite appears within one cycle of the raise. The sweeps cover every flag combination for general raises and every interrupt level for debug raises, in both double-PC variants.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;

  localparam int LVL_W = 4;

  typedef struct packed {
    logic             um;
    logic             excm;
    logic [LVL_W-1:0] intlevel;
  } ps_t;

  localparam int PS_W = $bits(ps_t);

  // vector one-hot bit positions
  localparam int VEC_USER   = 0;
  localparam int VEC_KERNEL = 1;
  localparam int VEC_DOUBLE = 2;
  localparam int VEC_DEBUG  = 3;

  // register select map
  localparam int SEL_STATUS   = 0;
  localparam int SEL_CAUSE    = 1;
  localparam int SEL_VADDR    = 2;
  localparam int SEL_DEPC     = 3;
  localparam int SEL_DBGCAUSE = 4;
  localparam int SEL_EPC_BASE = 8;
  localparam int SEL_EPS_BASE = 16;

  function automatic logic [3:0] general_vector(input logic excm, input logic um);
    logic [3:0] v;
    v = '0;
    if (excm)    v[VEC_DOUBLE] = 1'b1;
    else if (um) v[VEC_USER]   = 1'b1;
    else         v[VEC_KERNEL] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_dispatch_pkg::*;
#(
  parameter int DEBUG_LEVEL = 6
) (
  input  logic       raise_gen,
  input  logic       raise_dbg,
  input  ps_t        cur_ps,
  output logic       take_gen,
  output logic       take_dbg,
  output logic       drop_gen,
  output logic [3:0] vec_next
);

  logic dbg_allowed;

  assign dbg_allowed = cur_ps.intlevel < LVL_W'(DEBUG_LEVEL);
  assign take_dbg    = raise_dbg && dbg_allowed;
  assign take_gen    = raise_gen && !take_dbg;
  assign drop_gen    = raise_gen && take_dbg;

  always_comb begin
    vec_next = '0;
    if (take_dbg)      vec_next[VEC_DEBUG] = 1'b1;
    else if (take_gen) vec_next = general_vector(cur_ps.excm, cur_ps.um);
  end

endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs
  import exc_dispatch_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CAUSE_W     = 6,
  parameter int NUM_LEVELS  = 7,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1,
  parameter int SEL_W       = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_gen,
  input  logic               take_dbg,
  input  logic               with_vaddr,
  input  logic [DATA_W-1:0]  fault_pc,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [DATA_W-1:0]  fault_vaddr,
  input  logic [CAUSE_W-1:0] dbg_cause,
  input  logic               sw_we,
  input  logic [SEL_W-1:0]   sw_sel,
  input  logic [DATA_W-1:0]  sw_wdata,
  output ps_t                ps_q,
  output logic [DATA_W-1:0]  sw_rdata
);

  logic [CAUSE_W-1:0] exccause_q;
  logic [DATA_W-1:0]  excvaddr_q;
  logic [DATA_W-1:0]  depc_q;
  logic [CAUSE_W-1:0] dbgcause_q;
  logic [DATA_W-1:0]  epc_q [1:NUM_LEVELS];
  logic [DATA_W-1:0]  eps_q [2:NUM_LEVELS];

  logic [DATA_W-1:0]  status_word;
  logic               to_depc;
  logic               sw_ok;

  assign status_word = DATA_W'(ps_q);
  assign to_depc     = ps_q.excm && HAS_DEPC;
  assign sw_ok       = sw_we && !take_gen && !take_dbg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q       <= '0;
      exccause_q <= '0;
      excvaddr_q <= '0;
      dbgcause_q <= '0;
      for (int k = 1; k <= NUM_LEVELS; k++) epc_q[k] <= '0;
      for (int k = 2; k <= NUM_LEVELS; k++) eps_q[k] <= '0;
    end else if (take_dbg) begin
      dbgcause_q         <= dbg_cause;
      epc_q[DEBUG_LEVEL] <= fault_pc;
      eps_q[DEBUG_LEVEL] <= status_word;
      ps_q.intlevel      <= LVL_W'(DEBUG_LEVEL);
      ps_q.excm          <= 1'b1;
    end else if (take_gen) begin
      exccause_q <= cause;
      if (with_vaddr) excvaddr_q <= fault_vaddr;
      if (!to_depc)   epc_q[1]   <= fault_pc;
      ps_q.excm  <= 1'b1;
    end else if (sw_ok) begin
      if (sw_sel == SEL_W'(SEL_STATUS))   ps_q       <= ps_t'(sw_wdata[PS_W-1:0]);
      if (sw_sel == SEL_W'(SEL_CAUSE))    exccause_q <= sw_wdata[CAUSE_W-1:0];
      if (sw_sel == SEL_W'(SEL_VADDR))    excvaddr_q <= sw_wdata;
      if (sw_sel == SEL_W'(SEL_DBGCAUSE)) dbgcause_q <= sw_wdata[CAUSE_W-1:0];
      for (int k = 1; k <= NUM_LEVELS; k++)
        if (sw_sel == SEL_W'(SEL_EPC_BASE + k)) epc_q[k] <= sw_wdata;
      for (int k = 2; k <= NUM_LEVELS; k++)
        if (sw_sel == SEL_W'(SEL_EPS_BASE + k)) eps_q[k] <= sw_wdata;
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  depc_q <= '0;
        else if (take_gen && !take_dbg && ps_q.excm) depc_q <= fault_pc;
        else if (sw_ok && sw_sel == SEL_W'(SEL_DEPC)) depc_q <= sw_wdata;
      end
    end else begin : g_no_depc
      assign depc_q = '0;
    end
  endgenerate

  always_comb begin
    sw_rdata = '0;
    if (sw_sel == SEL_W'(SEL_STATUS))   sw_rdata = status_word;
    if (sw_sel == SEL_W'(SEL_CAUSE))    sw_rdata = DATA_W'(exccause_q);
    if (sw_sel == SEL_W'(SEL_VADDR))    sw_rdata = excvaddr_q;
    if (sw_sel == SEL_W'(SEL_DEPC))     sw_rdata = depc_q;
    if (sw_sel == SEL_W'(SEL_DBGCAUSE)) sw_rdata = DATA_W'(dbgcause_q);
    for (int k = 1; k <= NUM_LEVELS; k++)
      if (sw_sel == SEL_W'(SEL_EPC_BASE + k)) sw_rdata = epc_q[k];
    for (int k = 2; k <= NUM_LEVELS; k++)
      if (sw_sel == SEL_W'(SEL_EPS_BASE + k)) sw_rdata = eps_q[k];
  end

  // R4: general raise leaves exception mode set and the cause recorded
  assert_excm_after_gen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_gen |=> (ps_q.excm && exccause_q == $past(cause)));

  // R4: user mode is never altered by a raise
  assert_um_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_gen || take_dbg) |=> ps_q.um == $past(ps_q.um));

  // R6: debug raise lands at the debug level with exception mode set
  assert_dbg_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |=> (ps_q.intlevel == LVL_W'(DEBUG_LEVEL) && ps_q.excm
                  && eps_q[DEBUG_LEVEL] == $past(status_word)));

endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_dispatch_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CAUSE_W     = 6,
  parameter int NUM_LEVELS  = 7,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1,
  parameter int SEL_W       = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_gen,
  input  logic               raise_dbg,
  input  logic               with_vaddr,
  input  logic [DATA_W-1:0]  fault_pc,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [DATA_W-1:0]  fault_vaddr,
  input  logic [CAUSE_W-1:0] dbg_cause,
  input  logic               sw_we,
  input  logic [SEL_W-1:0]   sw_sel,
  input  logic [DATA_W-1:0]  sw_wdata,
  output logic [DATA_W-1:0]  sw_rdata,
  output logic [3:0]         vec_sel,
  output logic               vec_taken,
  output logic               gen_dropped
);

  ps_t        cur_ps;
  logic       take_gen;
  logic       take_dbg;
  logic       drop_gen;
  logic [3:0] vec_next;

  exc_arbiter #(.DEBUG_LEVEL(DEBUG_LEVEL)) u_arb (
    .raise_gen (raise_gen),
    .raise_dbg (raise_dbg),
    .cur_ps    (cur_ps),
    .take_gen  (take_gen),
    .take_dbg  (take_dbg),
    .drop_gen  (drop_gen),
    .vec_next  (vec_next)
  );

  exc_save_regs #(
    .DATA_W(DATA_W), .CAUSE_W(CAUSE_W), .NUM_LEVELS(NUM_LEVELS),
    .DEBUG_LEVEL(DEBUG_LEVEL), .HAS_DEPC(HAS_DEPC), .SEL_W(SEL_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_gen    (take_gen),
    .take_dbg    (take_dbg),
    .with_vaddr  (with_vaddr),
    .fault_pc    (fault_pc),
    .cause       (cause),
    .fault_vaddr (fault_vaddr),
    .dbg_cause   (dbg_cause),
    .sw_we       (sw_we),
    .sw_sel      (sw_sel),
    .sw_wdata    (sw_wdata),
    .ps_q        (cur_ps),
    .sw_rdata    (sw_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_sel     <= '0;
      vec_taken   <= 1'b0;
      gen_dropped <= 1'b0;
    end else begin
      vec_sel     <= vec_next;
      vec_taken   <= take_gen || take_dbg;
      gen_dropped <= drop_gen;
    end
  end

  // R9: one vector bit exactly when a vector is taken
  assert_onehot_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken |-> $countones(vec_sel) == 1);
  assert_idle_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_taken |-> vec_sel == 4'b0000);

  // R8: a dropped general raise coincides with the debug vector
  assert_drop_debug_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gen_dropped |-> (vec_taken && vec_sel[VEC_DEBUG]));

  // R7: a lone debug raise at or above the debug level is not taken
  assert_dbg_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_dbg && !raise_gen && cur_ps.intlevel >= LVL_W'(DEBUG_LEVEL)) |=> !vec_taken);

  // R3: double vector only when exception mode was already set
  assert_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_taken && vec_sel[VEC_DOUBLE]) |-> $past(cur_ps.excm));

endmodule

// File: tb/exc_dispatch_test.sv
`timescale 1ns/1ps
module exc_dispatch_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise_gen = 0, raise_dbg = 0, with_vaddr = 0;
  logic [31:0] fault_pc = '0, fault_vaddr = '0;
  logic [5:0]  cause = '0, dbg_cause = '0;
  logic        sw_we = 0;
  logic [4:0]  sw_sel = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata, nd_rdata;
  logic [3:0]  vec_sel, nd_vsel;
  logic        vec_taken, gen_dropped, nd_taken, nd_drop;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic tk, dp;
  logic [3:0] vs;

  always #2.5 clk = ~clk;

  exc_dispatch uut (
    .clk(clk), .rst_n(rst_n), .raise_gen(raise_gen), .raise_dbg(raise_dbg),
    .with_vaddr(with_vaddr), .fault_pc(fault_pc), .cause(cause),
    .fault_vaddr(fault_vaddr), .dbg_cause(dbg_cause), .sw_we(sw_we),
    .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .vec_sel(vec_sel), .vec_taken(vec_taken), .gen_dropped(gen_dropped));

  exc_dispatch #(.HAS_DEPC(1'b0)) uut_nd (
    .clk(clk), .rst_n(rst_n), .raise_gen(raise_gen), .raise_dbg(raise_dbg),
    .with_vaddr(with_vaddr), .fault_pc(fault_pc), .cause(cause),
    .fault_vaddr(fault_vaddr), .dbg_cause(dbg_cause), .sw_we(sw_we),
    .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(nd_rdata),
    .vec_sel(nd_vsel), .vec_taken(nd_taken), .gen_dropped(nd_drop));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int sel, output logic [31:0] v);
    sw_sel = 5'(sel);
    #0.5;
    v = sw_rdata;
  endtask

  task automatic rdn(input int sel, output logic [31:0] v);
    sw_sel = 5'(sel);
    #0.5;
    v = nd_rdata;
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    sw_we = 1; sw_sel = 5'(sel); sw_wdata = d;
    @(posedge clk); @(negedge clk);
    sw_we = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic fire(input logic g, input logic d, input logic wv,
                      input logic [31:0] pc, input logic [31:0] va,
                      input logic [5:0] c, input logic [5:0] dc);
    raise_gen = g; raise_dbg = d; with_vaddr = wv;
    fault_pc = pc; fault_vaddr = va; cause = c; dbg_cause = dc;
    @(posedge clk); @(negedge clk);
    raise_gen = 0; raise_dbg = 0; with_vaddr = 0; sw_we = 0;
    tk = vec_taken; vs = vec_sel; dp = gen_dropped;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 vec_taken", 32'(vec_taken), 0);
    chk("R1 vec_sel", 32'(vec_sel), 0);
    chk("R1 gen_dropped", 32'(gen_dropped), 0);
    for (int s = 0; s < 32; s++) begin
      rd(s, v);
      chk("R1 register zero", v, 0);
    end

    // R2 R3 R4 R5: general raise over all flag combinations
    for (int i = 0; i < 8; i++) begin
      logic um, ex, wv;
      logic [31:0] pc, va, mark;
      logic [5:0] c;
      um = i[2]; ex = i[1]; wv = i[0];
      pc = 32'h1000_0000 + 32'(i * 16);
      va = 32'hBEEF_0000 + 32'(i);
      mark = 32'h5A5A_0000 + 32'(i);
      c = 6'(i + 1);
      wr(0, {26'd0, um, ex, 4'd3});
      wr(2, mark);
      wr(3, 32'd0);
      wr(9, 32'd0);
      fire(1, 0, wv, pc, va, c, 6'd0);
      chk("R2/R3 vec_taken", 32'(tk), 1);
      chk("R2/R3 vector", 32'(vs), ex ? 32'h4 : (um ? 32'h1 : 32'h2));
      chk("R8 no drop", 32'(dp), 0);
      rd(1, v);  chk("R4 cause", v, 32'(c));
      rd(0, v);  chk("R4 status", v, {26'd0, um, 1'b1, 4'd3});
      rd(2, v);  chk("R5 vaddr", v, wv ? va : mark);
      if (ex) begin
        rd(3, v);  chk("R3 depc", v, pc);
        rd(9, v);  chk("R3 epc1 untouched", v, 0);
        rdn(9, v); chk("R3 no-depc epc1", v, pc);
        rdn(3, v); chk("R3 no-depc reads zero", v, 0);
      end else begin
        rd(9, v);  chk("R2 epc1", v, pc);
        rd(3, v);  chk("R2 depc untouched", v, 0);
      end
      tick();
      chk("R9 pulse ends", 32'(vec_taken), 0);
      chk("R9 vec idle", 32'(vec_sel), 0);
    end

    // R6 R7: debug raise over every interrupt level (debug level 6)
    for (int l = 0; l < 16; l++) begin
      logic [31:0] pc;
      pc = 32'h2000_0000 + 32'(l);
      wr(0, 32'(l));
      wr(4, 32'h2A);
      wr(14, 32'd0);
      wr(22, 32'd0);
      fire(0, 1, 0, pc, 32'd0, 6'd0, 6'(l + 1));
      if (l < 6) begin
        chk("R6 taken", 32'(tk), 1);
        chk("R6 debug vector", 32'(vs), 32'h8);
        rd(4, v);  chk("R6 debug cause", v, 32'(l + 1));
        rd(14, v); chk("R6 epc slot", v, pc);
        rd(22, v); chk("R6 eps slot", v, 32'(l));
        rd(0, v);  chk("R6 status", v, 32'h16);
      end else begin
        chk("R7 not taken", 32'(tk), 0);
        rd(4, v);  chk("R7 cause kept", v, 32'h2A);
        rd(14, v); chk("R7 epc kept", v, 0);
        rd(0, v);  chk("R7 status kept", v, 32'(l));
      end
    end

    // R6: full status word saved, user mode kept
    wr(0, 32'h33);
    fire(0, 1, 0, 32'h3000_0000, 32'd0, 6'd0, 6'd9);
    rd(22, v); chk("R6 eps full word", v, 32'h33);
    rd(0, v);  chk("R6 status after", v, 32'h36);

    // R8: simultaneous raises, debug wins
    wr(0, 32'd0); wr(1, 32'h11); wr(9, 32'd0); wr(2, 32'h77);
    fire(1, 1, 1, 32'h4000_0000, 32'h9999, 6'd5, 6'd7);
    chk("R8 taken", 32'(tk), 1);
    chk("R8 debug vector", 32'(vs), 32'h8);
    chk("R8 dropped", 32'(dp), 1);
    rd(1, v); chk("R8 cause kept", v, 32'h11);
    rd(9, v); chk("R8 epc1 kept", v, 0);
    rd(2, v); chk("R8 vaddr kept", v, 32'h77);
    tick();
    chk("R8 drop pulse ends", 32'(gen_dropped), 0);

    // R7 R8: simultaneous with debug gated off, general proceeds
    wr(0, 32'd7);
    fire(1, 1, 0, 32'h4100_0000, 32'd0, 6'd12, 6'd7);
    chk("R7 general taken", 32'(tk), 1);
    chk("R7 kernel vector", 32'(vs), 32'h2);
    chk("R8 not dropped", 32'(dp), 0);
    rd(1, v); chk("R7 cause", v, 32'd12);

    // R10: raise beats a same-cycle write
    wr(0, 32'd0);
    sw_we = 1; sw_sel = 5'd1; sw_wdata = 32'h05;
    fire(1, 0, 0, 32'h5000_0000, 32'd0, 6'd9, 6'd0);
    rd(1, v); chk("R10 raise wins", v, 32'd9);
    // R10: plain write and readback
    wr(17 + 6, 32'hCAFE_F00D);
    rd(23, v); chk("R10 eps7 write", v, 32'hCAFE_F00D);
    // R10: unused selects ignore writes
    for (int s = 0; s < 32; s++) begin
      if ((s >= 5 && s <= 8) || s == 16 || s == 17 || s >= 24) begin
        wr(s, 32'hFFFF_FFFF);
        rd(s, v); chk("R10 unused reads zero", v, 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule